// File: doc/BRIEF.md
# Hub master link router

This block is a memory-mapped hub master placed behind an upstream register-bus port. The low part of the upstream address space holds a bank of control registers. Above that sits a row of fixed 512 KiB windows, one for each downstream link. An access that falls in a link window is decoded to a link index and an offset within the window. It is handed to that link's request channel only when the link is implemented and its enable bit is set. Any other window access completes at once with an error response, and the block records the offending address.

The control bank holds the following:
- a mode word with defined fields only, plus a delay word and a clock-rate word;
- an error-control word;
- a link-enable word, changed through separate set and clear offsets and read back at its own offset;
- a read-only version word that reports the implemented link count;
- a read-only error status and error address.

Two write-only command offsets produce single-cycle reset pulses. One of these commands also returns most of the bank to zero. A recognised break pattern written into a link window becomes a one-cycle break strobe for that link, and no request is sent for it.

Top module: `hub_link_router`

## Requirements
- R1: A register access completes one cycle after acceptance with up_rsp_err=0. Offset 0x0 stores and returns only the mode fields selected by mask 0xDFFFFF10: bits 31, 30, 28, 27:18, 17:8 and 4. Offsets 0x4 (delay) and 0x8 (clock rate) store all 32 bits. Offset 0x2E0 (error control) keeps bits 15 and 14 only. Write responses carry zero data.
- R2: Link n is enable bit 31-n. A write to 0x18 ORs the written bits into the enable word. A read of 0x10 returns the enable word. Bits for links at or above NLINKS always read 0. link_en[n] mirrors bit 31-n.
- R3: A write to 0x20 clears every enable bit that is set in the written word. A write to 0x10 changes nothing.
- R4: A read of 0x18 returns the plug-detect inputs, MSB-first: bit 31-n is plug_det[n], and all other bits are 0.
- R5: A read of 0x74 returns {16'h0, NLINKS[7:0], VERSION_ID[7:0]}.
- R6: An address with window index w = up_addr[22:19] ≥ 1 targets link w-1 at offset up_addr[18:0]. When granted, that link's dn_valid rises one cycle after acceptance, together with dn_write, dn_addr (the offset) and dn_wdata. These stay held until dn_ready. The response follows one cycle after the handshake and carries dn_rdata with no error.
- R7: A window access to a disabled link, or to a link index ≥ NLINKS, is answered one cycle after acceptance with up_rsp_err=1. No dn_valid is raised. Bit 31 of the error status (0x1D0 read) becomes 1, and the error address (0x70) holds the upstream address.
- R8: A granted write of 0xC0DE0000 to window offset 0x4 pulses dn_break for that link for exactly one cycle, one cycle after acceptance. It completes without error and raises no dn_valid. Other data written to offset 0x4 is forwarded as an ordinary request.
- R9: A write to 0xD0 produces single-cycle pulses one cycle after acceptance: bit 29 drives rst_masters, bit 28 drives rst_links, and bit 26 drives clr_parity.
- R10: A write to 0xD0 with bit 27 set returns mode, delay, error control and link enables to zero, as seen from the next cycle. The clock-rate word is kept.
- R11: A write to 0x1D0 with bit 31 pulses bridge_gen_rst, and with bit 30 pulses bridge_err_rst, each for one cycle. Either bit clears the error status and the error address.
- R12: After reset, up_ready=1, all dn_valid and up_rsp_valid are 0, and every register reads 0. up_ready is 0 while a forwarded request waits for dn_ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| up_valid | input | 1 | Upstream request valid |
| up_ready | output | 1 | Upstream request can be accepted |
| up_write | input | 1 | 1 = write, 0 = read |
| up_addr | input | 23 | Upstream byte address |
| up_wdata | input | 32 | Upstream write data |
| up_rsp_valid | output | 1 | Response strobe |
| up_rsp_err | output | 1 | Response carries an error |
| up_rdata | output | 32 | Response read data |
| plug_det | input | NLINKS | Plug-detect level per link |
| link_en | output | NLINKS | Per-link enable gate state |
| dn_valid | output | NLINKS | Downstream request valid per link |
| dn_ready | input | NLINKS | Downstream request accepted per link |
| dn_write | output | 1 | Downstream request is a write |
| dn_addr | output | 19 | Offset inside the link window |
| dn_wdata | output | 32 | Downstream write data |
| dn_rdata | input | 32 | Downstream read data, taken at handshake |
| dn_break | output | NLINKS | One-cycle break strobe per link |
| rst_masters | output | 1 | Pulse: reset all masters |
| rst_links | output | 1 | Pulse: reset all link controllers |
| clr_parity | output | 1 | Pulse: clear parity error |
| bridge_gen_rst | output | 1 | Pulse: general bridge reset |
| bridge_err_rst | output | 1 | Pulse: bridge error reset |

## Verification
The window decoder is swept over every window index, from link 0 up to index 14. This is done under three enable patterns: a sparse mask, all enables set, and none set. The sweep separates three cases: forwarding, rejection because a link is disabled, and rejection because the link is not implemented. It alternates reads and writes and varies the downstream ready delay, which tests request holding and the capture of read data. Each enable bit is set and cleared on its own, which exposes any MSB-first mapping error. Plug-detect patterns and mode words of all-ones, alternating bits and single bits show the field masking. The break pattern is sent to enabled and disabled links and compared with near-miss data. The reset commands are combined with a later read-back to check which registers survive.

// File: rtl/hub_pkg.sv
package hub_pkg;
  localparam int HUB_ADDR_W = 23;
  localparam int WIN_SHIFT  = 19;
  localparam int IDX_W      = HUB_ADDR_W - WIN_SHIFT;
  localparam int MAX_LINKS  = 8;

  localparam logic [WIN_SHIFT-1:0] OFF_MODE  = 19'h00000;
  localparam logic [WIN_SHIFT-1:0] OFF_DELAY = 19'h00004;
  localparam logic [WIN_SHIFT-1:0] OFF_CRATE = 19'h00008;
  localparam logic [WIN_SHIFT-1:0] OFF_ENRD  = 19'h00010;
  localparam logic [WIN_SHIFT-1:0] OFF_ENSET = 19'h00018;
  localparam logic [WIN_SHIFT-1:0] OFF_ENCLR = 19'h00020;
  localparam logic [WIN_SHIFT-1:0] OFF_EADDR = 19'h00070;
  localparam logic [WIN_SHIFT-1:0] OFF_VER   = 19'h00074;
  localparam logic [WIN_SHIFT-1:0] OFF_PRST  = 19'h000D0;
  localparam logic [WIN_SHIFT-1:0] OFF_ESTAT = 19'h001D0;
  localparam logic [WIN_SHIFT-1:0] OFF_ECTL  = 19'h002E0;

  localparam logic [WIN_SHIFT-1:0] BRK_OFF  = 19'h00004;
  localparam logic [31:0]          BRK_WORD = 32'hC0DE_0000;

  localparam logic [31:0] MODE_MASK = 32'hDFFF_FF10;
  localparam logic [31:0] ECTL_MASK = 32'h0000_C000;

  // Enable-word bit that stands for a link (MSB-first).
  function automatic logic [31:0] link_bit(input int n);
    return 32'h8000_0000 >> n;
  endfunction

  // Mask of enable bits that correspond to implemented links.
  function automatic logic [31:0] impl_mask(input int nlinks);
    return ~(32'hFFFF_FFFF >> nlinks);
  endfunction
endpackage

// File: rtl/hub_ctrl_regs.sv
module hub_ctrl_regs
  import hub_pkg::*;
#(
  parameter int          NLINKS     = 8,
  parameter logic [7:0]  VERSION_ID = 8'h21
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 acc,
  input  logic                 wr,
  input  logic [WIN_SHIFT-1:0] off,
  input  logic [31:0]          wdata,
  input  logic [NLINKS-1:0]    plug_det,
  input  logic                 deny_evt,
  input  logic [31:0]          deny_addr,
  output logic [31:0]          rdata,
  output logic [NLINKS-1:0]    link_en,
  output logic                 rst_masters_p,
  output logic                 rst_links_p,
  output logic                 clr_parity_p,
  output logic                 br_gen_p,
  output logic                 br_err_p
);
  localparam logic [31:0] EN_IMPL = impl_mask(NLINKS);
  localparam logic [7:0]  NL8     = 8'(NLINKS);

  logic [31:0] mode_q, delay_q, crate_q, ectl_q, en_q, eaddr_q;
  logic        eflag_q;
  logic [31:0] plug_vec;

  logic wr_hit;
  logic sel_mode, sel_delay, sel_crate, sel_set, sel_clr, sel_prst, sel_estat, sel_ectl;
  logic rst_regs_evt, err_clr_evt;

  assign wr_hit    = acc && wr;
  assign sel_mode  = (off == OFF_MODE);
  assign sel_delay = (off == OFF_DELAY);
  assign sel_crate = (off == OFF_CRATE);
  assign sel_set   = (off == OFF_ENSET);
  assign sel_clr   = (off == OFF_ENCLR);
  assign sel_prst  = (off == OFF_PRST);
  assign sel_estat = (off == OFF_ESTAT);
  assign sel_ectl  = (off == OFF_ECTL);

  assign rst_regs_evt = wr_hit && sel_prst && wdata[27];
  assign err_clr_evt  = wr_hit && sel_estat && (wdata[31] || wdata[30]);

  genvar gi;
  generate
    for (gi = 0; gi < 32; gi++) begin : g_plug
      if (gi < NLINKS) begin : g_on
        assign plug_vec[31-gi] = plug_det[gi];
        assign link_en[gi]     = en_q[31-gi];
      end else begin : g_off
        assign plug_vec[31-gi] = 1'b0;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q  <= '0;
      delay_q <= '0;
      crate_q <= '0;
      ectl_q  <= '0;
      en_q    <= '0;
    end else begin
      if (wr_hit && sel_crate) crate_q <= wdata;
      if (rst_regs_evt) begin
        mode_q  <= '0;
        delay_q <= '0;
        ectl_q  <= '0;
        en_q    <= '0;
      end else if (wr_hit) begin
        if (sel_mode)  mode_q  <= wdata & MODE_MASK;
        if (sel_delay) delay_q <= wdata;
        if (sel_ectl)  ectl_q  <= wdata & ECTL_MASK;
        if (sel_set)   en_q    <= en_q | (wdata & EN_IMPL);
        if (sel_clr)   en_q    <= en_q & ~wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      eflag_q <= 1'b0;
      eaddr_q <= '0;
    end else if (err_clr_evt) begin
      eflag_q <= 1'b0;
      eaddr_q <= '0;
    end else if (deny_evt) begin
      eflag_q <= 1'b1;
      eaddr_q <= deny_addr;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rst_masters_p <= 1'b0;
      rst_links_p   <= 1'b0;
      clr_parity_p  <= 1'b0;
      br_gen_p      <= 1'b0;
      br_err_p      <= 1'b0;
    end else begin
      rst_masters_p <= wr_hit && sel_prst  && wdata[29];
      rst_links_p   <= wr_hit && sel_prst  && wdata[28];
      clr_parity_p  <= wr_hit && sel_prst  && wdata[26];
      br_gen_p      <= wr_hit && sel_estat && wdata[31];
      br_err_p      <= wr_hit && sel_estat && wdata[30];
    end
  end

  always_comb begin
    case (off)
      OFF_MODE:  rdata = mode_q;
      OFF_DELAY: rdata = delay_q;
      OFF_CRATE: rdata = crate_q;
      OFF_ENRD:  rdata = en_q;
      OFF_ENSET: rdata = plug_vec;
      OFF_EADDR: rdata = eaddr_q;
      OFF_VER:   rdata = {16'h0, NL8, VERSION_ID};
      OFF_ESTAT: rdata = {eflag_q, 31'h0};
      OFF_ECTL:  rdata = ectl_q;
      default:   rdata = '0;
    endcase
  end

  a_r10_regs_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    rst_regs_evt |=> (mode_q == '0 && delay_q == '0 && ectl_q == '0 && en_q == '0));

  a_r3_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && sel_clr) |=> ((en_q & $past(wdata)) == '0));

  a_r7_deny_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (deny_evt && !err_clr_evt) |=> (eflag_q && eaddr_q == $past(deny_addr)));

  a_r11_err_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    err_clr_evt |=> (!eflag_q && eaddr_q == '0));

  a_r9_pulse_from_write: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_masters_p || rst_links_p || clr_parity_p) |-> $past(wr_hit && sel_prst));
endmodule

// File: rtl/hub_addr_router.sv
module hub_addr_router
  import hub_pkg::*;
#(
  parameter int NLINKS = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  up_valid,
  output logic                  up_ready,
  input  logic                  up_write,
  input  logic [HUB_ADDR_W-1:0] up_addr,
  input  logic [31:0]           up_wdata,
  output logic                  rsp_valid,
  output logic                  rsp_err,
  output logic [31:0]           rsp_rdata,
  input  logic [31:0]           reg_rdata,
  input  logic [NLINKS-1:0]     link_en,
  output logic                  reg_acc,
  output logic                  deny_evt,
  output logic [NLINKS-1:0]     dn_valid,
  input  logic [NLINKS-1:0]     dn_ready,
  output logic                  dn_write,
  output logic [WIN_SHIFT-1:0]  dn_addr,
  output logic [31:0]           dn_wdata,
  input  logic [31:0]           dn_rdata,
  output logic [NLINKS-1:0]     dn_break
);
  localparam int NWIN = 1 << IDX_W;

  logic [IDX_W-1:0]     win_idx, link_num, cur_link_q;
  logic [WIN_SHIFT-1:0] win_off;
  logic [NWIN-1:0]      en_pad, rdy_pad;
  logic is_reg, granted, is_brk, acc;
  logic fwd_evt, brk_evt, dn_hs;
  logic busy_q;

  assign win_idx  = up_addr[HUB_ADDR_W-1:WIN_SHIFT];
  assign win_off  = up_addr[WIN_SHIFT-1:0];
  assign link_num = win_idx - IDX_W'(1);
  assign is_reg   = (win_idx == '0);
  assign en_pad   = NWIN'(link_en);
  assign rdy_pad  = NWIN'(dn_ready);
  assign granted  = en_pad[link_num];
  assign is_brk   = up_write && (win_off == BRK_OFF) && (up_wdata == BRK_WORD);

  assign up_ready = !busy_q;
  assign acc      = up_valid && up_ready;
  assign reg_acc  = acc && is_reg;
  assign deny_evt = acc && !is_reg && !granted;
  assign fwd_evt  = acc && !is_reg && granted && !is_brk;
  assign brk_evt  = acc && !is_reg && granted && is_brk;
  assign dn_hs    = busy_q && rdy_pad[cur_link_q];

  genvar gi;
  generate
    for (gi = 0; gi < NLINKS; gi++) begin : g_link
      assign dn_valid[gi] = busy_q && (cur_link_q == IDX_W'(gi));
      always_ff @(posedge clk) begin
        if (!rst_n) dn_break[gi] <= 1'b0;
        else        dn_break[gi] <= brk_evt && (link_num == IDX_W'(gi));
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q     <= 1'b0;
      cur_link_q <= '0;
      dn_write   <= 1'b0;
      dn_addr    <= '0;
      dn_wdata   <= '0;
    end else if (fwd_evt) begin
      busy_q     <= 1'b1;
      cur_link_q <= link_num;
      dn_write   <= up_write;
      dn_addr    <= win_off;
      dn_wdata   <= up_wdata;
    end else if (dn_hs) begin
      busy_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= reg_acc || deny_evt || brk_evt || dn_hs;
      rsp_err   <= deny_evt;
      if (dn_hs)                     rsp_rdata <= dn_write ? 32'h0 : dn_rdata;
      else if (reg_acc && !up_write) rsp_rdata <= reg_rdata;
      else                           rsp_rdata <= '0;
    end
  end

  a_r6_one_link: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dn_valid));

  a_r6_hold_until_ready: assert property (@(posedge clk) disable iff (!rst_n)
    ((dn_valid != '0) && ((dn_valid & dn_ready) == '0)) |=>
      ($stable(dn_valid) && $stable(dn_addr) && $stable(dn_wdata) && $stable(dn_write)));

  a_r7_err_not_forwarded: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> (dn_valid == '0 && dn_break == '0));

  a_r8_break_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dn_break) && ((dn_break & ~link_en) == '0));

  a_r12_rsp_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(acc || dn_hs));
endmodule

// File: rtl/hub_link_router.sv
module hub_link_router
  import hub_pkg::*;
#(
  parameter int         NLINKS     = 8,
  parameter logic [7:0] VERSION_ID = 8'h21
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  up_valid,
  output logic                  up_ready,
  input  logic                  up_write,
  input  logic [HUB_ADDR_W-1:0] up_addr,
  input  logic [31:0]           up_wdata,
  output logic                  up_rsp_valid,
  output logic                  up_rsp_err,
  output logic [31:0]           up_rdata,
  input  logic [NLINKS-1:0]     plug_det,
  output logic [NLINKS-1:0]     link_en,
  output logic [NLINKS-1:0]     dn_valid,
  input  logic [NLINKS-1:0]     dn_ready,
  output logic                  dn_write,
  output logic [WIN_SHIFT-1:0]  dn_addr,
  output logic [31:0]           dn_wdata,
  input  logic [31:0]           dn_rdata,
  output logic [NLINKS-1:0]     dn_break,
  output logic                  rst_masters,
  output logic                  rst_links,
  output logic                  clr_parity,
  output logic                  bridge_gen_rst,
  output logic                  bridge_err_rst
);
  logic        reg_acc, deny_evt;
  logic [31:0] reg_rdata;

  hub_addr_router #(.NLINKS(NLINKS)) u_router (
    .clk       (clk),
    .rst_n     (rst_n),
    .up_valid  (up_valid),
    .up_ready  (up_ready),
    .up_write  (up_write),
    .up_addr   (up_addr),
    .up_wdata  (up_wdata),
    .rsp_valid (up_rsp_valid),
    .rsp_err   (up_rsp_err),
    .rsp_rdata (up_rdata),
    .reg_rdata (reg_rdata),
    .link_en   (link_en),
    .reg_acc   (reg_acc),
    .deny_evt  (deny_evt),
    .dn_valid  (dn_valid),
    .dn_ready  (dn_ready),
    .dn_write  (dn_write),
    .dn_addr   (dn_addr),
    .dn_wdata  (dn_wdata),
    .dn_rdata  (dn_rdata),
    .dn_break  (dn_break)
  );

  hub_ctrl_regs #(.NLINKS(NLINKS), .VERSION_ID(VERSION_ID)) u_regs (
    .clk           (clk),
    .rst_n         (rst_n),
    .acc           (reg_acc),
    .wr            (up_write),
    .off           (up_addr[WIN_SHIFT-1:0]),
    .wdata         (up_wdata),
    .plug_det      (plug_det),
    .deny_evt      (deny_evt),
    .deny_addr     (32'(up_addr)),
    .rdata         (reg_rdata),
    .link_en       (link_en),
    .rst_masters_p (rst_masters),
    .rst_links_p   (rst_links),
    .clr_parity_p  (clr_parity),
    .br_gen_p      (bridge_gen_rst),
    .br_err_p      (bridge_err_rst)
  );
endmodule

// File: tb/hub_link_router_tb.sv
module hub_link_router_tb;
  localparam int NL = 6;
  localparam logic [7:0] VID = 8'h21;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic up_valid = 1'b0, up_write = 1'b0;
  logic [22:0] up_addr = '0;
  logic [31:0] up_wdata = '0;
  logic up_ready, up_rsp_valid, up_rsp_err;
  logic [31:0] up_rdata;
  logic [NL-1:0] plug_det = '0, link_en, dn_valid, dn_break;
  logic [NL-1:0] dn_ready = '0;
  logic dn_write;
  logic [18:0] dn_addr;
  logic [31:0] dn_wdata, dn_rdata = '0;
  logic rst_masters, rst_links, clr_parity, bridge_gen_rst, bridge_err_rst;

  always #5 clk = ~clk;

  hub_link_router #(.NLINKS(NL), .VERSION_ID(VID)) u_dut (
    .clk(clk), .rst_n(rst_n), .up_valid(up_valid), .up_ready(up_ready),
    .up_write(up_write), .up_addr(up_addr), .up_wdata(up_wdata),
    .up_rsp_valid(up_rsp_valid), .up_rsp_err(up_rsp_err), .up_rdata(up_rdata),
    .plug_det(plug_det), .link_en(link_en), .dn_valid(dn_valid), .dn_ready(dn_ready),
    .dn_write(dn_write), .dn_addr(dn_addr), .dn_wdata(dn_wdata), .dn_rdata(dn_rdata),
    .dn_break(dn_break), .rst_masters(rst_masters), .rst_links(rst_links),
    .clr_parity(clr_parity), .bridge_gen_rst(bridge_gen_rst), .bridge_err_rst(bridge_err_rst)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // Results of the last access.
  bit          g_rsp, g_err, g_rdy_ok;
  logic [31:0] g_rdata, g_dnwd;
  int          g_link;
  logic [18:0] g_dnaddr;
  logic        g_dnwr;
  logic [NL-1:0] g_brk, g_brk_after;
  logic [4:0]  g_pulse, g_pulse_after;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] lbit(input int n);
    return 32'h8000_0000 >> n;
  endfunction

  function automatic logic [31:0] dn_pattern(input int link, input logic [18:0] a);
    return 32'hD000_0000 | (32'(link) << 20) | 32'(a);
  endfunction

  function automatic logic [22:0] win_addr(input int link, input logic [18:0] off);
    return {4'(link + 1), off};
  endfunction

  task automatic acc(input bit w, input logic [22:0] a, input logic [31:0] d, input int dly);
    int guard;
    g_rsp = 0; g_err = 0; g_rdata = '0; g_link = -1; g_rdy_ok = 1;
    g_dnaddr = '0; g_dnwr = 0; g_dnwd = '0;
    @(negedge clk);
    up_valid = 1; up_write = w; up_addr = a; up_wdata = d;
    guard = 0;
    while (!up_ready && guard < 50) begin @(negedge clk); guard++; end
    @(posedge clk);
    @(negedge clk);
    up_valid = 0;
    g_pulse = {rst_masters, rst_links, clr_parity, bridge_gen_rst, bridge_err_rst};
    g_brk = dn_break;
    if (up_rsp_valid) begin
      g_rsp = 1; g_err = up_rsp_err; g_rdata = up_rdata;
    end else if (dn_valid != '0) begin
      for (int k = 0; k < NL; k++) if (dn_valid[k]) g_link = k;
      g_dnaddr = dn_addr; g_dnwr = dn_write; g_dnwd = dn_wdata;
      for (int k = 0; k < dly; k++) begin
        if (up_ready || dn_valid == '0) g_rdy_ok = 0;
        @(negedge clk);
      end
      if (up_ready) g_rdy_ok = 0;
      dn_ready[g_link] = 1'b1;
      dn_rdata = dn_pattern(g_link, g_dnaddr);
      @(posedge clk);
      @(negedge clk);
      dn_ready = '0;
      if (up_rsp_valid) begin g_rsp = 1; g_err = up_rsp_err; g_rdata = up_rdata; end
    end
    @(negedge clk);
    g_pulse_after = {rst_masters, rst_links, clr_parity, bridge_gen_rst, bridge_err_rst};
    g_brk_after = dn_break;
  endtask

  task automatic rd(input logic [22:0] a, output logic [31:0] v);
    acc(0, a, '0, 0);
    v = g_rdata;
  endtask

  task automatic wr(input logic [22:0] a, input logic [31:0] d);
    acc(1, a, d, 0);
  endtask

  logic [31:0] implm;

  task automatic sweep(input logic [NL-1:0] pat);
    logic [31:0] v, ev;
    logic [18:0] off;
    wr(23'h20, 32'hFFFF_FFFF);
    ev = '0;
    for (int n = 0; n < NL; n++) if (pat[n]) ev |= lbit(n);
    wr(23'h18, ev);
    rd(23'h10, v);
    chk(v == ev, "R2 enable pattern", v, ev);
    for (int l = 0; l < 15; l++) begin
      bit w = (l % 2) == 1;
      bit gr = (l < NL) && pat[l];
      off = 19'h00100 + 19'(l * 8);
      acc(w, win_addr(l, off), 32'hA000_0000 + 32'(l), l % 3);
      if (gr) begin
        chk(g_link == l, "R6 link select", 32'(g_link), 32'(l));
        chk(g_dnaddr == off && g_dnwr == w, "R6 offset/dir", {12'h0, g_dnwr, g_dnaddr}, {12'h0, w, off});
        if (w) chk(g_dnwd == 32'hA000_0000 + 32'(l), "R6 wdata", g_dnwd, 32'hA000_0000 + 32'(l));
        chk(g_rsp && !g_err && g_rdata == (w ? 32'h0 : dn_pattern(l, off)), "R6 response",
            g_rdata, w ? 32'h0 : dn_pattern(l, off));
        chk(g_rdy_ok, "R12 ready low while forwarding", 32'(g_rdy_ok), 1);
      end else begin
        chk(g_link == -1 && g_rsp && g_err, "R7 denied access", {g_rsp, g_err, 30'(g_link)}, 32'hC000_0000 | 32'h3FFF_FFFF);
        rd(23'h1D0, v);
        chk(v == 32'h8000_0000, "R7 error status", v, 32'h8000_0000);
        rd(23'h70, v);
        chk(v == 32'(win_addr(l, off)), "R7 error address", v, 32'(win_addr(l, off)));
        wr(23'h1D0, 32'h4000_0000);
        rd(23'h1D0, v);
        chk(v == 32'h0, "R11 error status cleared", v, 0);
      end
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] v, e;
    implm = ~(32'hFFFF_FFFF >> NL);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(up_ready && dn_valid == '0 && !up_rsp_valid, "R12 reset outputs",
        {up_ready, up_rsp_valid, 24'h0, 2'(0), dn_valid}, 32'h8000_0000);
    for (int i = 0; i < 12; i++) begin
      logic [18:0] offs [12] = '{19'h0, 19'h4, 19'h8, 19'h10, 19'h18, 19'h20,
                                 19'h70, 19'hD0, 19'h1D0, 19'h2E0, 19'h74, 19'h3C};
      rd({4'h0, offs[i]}, v);
      e = (offs[i] == 19'h74) ? {16'h0, 8'(NL), VID} : 32'h0;
      chk(v == e && g_rsp && !g_err, "R12 reset register value", v, e);
    end
    // R1 register storage and masks
    begin
      logic [31:0] pats [4] = '{32'hFFFF_FFFF, 32'hA5A5_A5A5, 32'h2000_0000, 32'h0004_0010};
      for (int i = 0; i < 4; i++) begin
        wr(23'h0, pats[i]);
        chk(g_rsp && !g_err && g_rdata == 0, "R1 write response", g_rdata, 0);
        rd(23'h0, v);
        chk(v == (pats[i] & 32'hDFFF_FF10), "R1 mode mask", v, pats[i] & 32'hDFFF_FF10);
        wr(23'h4, ~pats[i]); rd(23'h4, v);
        chk(v == ~pats[i], "R1 delay", v, ~pats[i]);
        wr(23'h8, pats[i] ^ 32'h1234_5678); rd(23'h8, v);
        chk(v == (pats[i] ^ 32'h1234_5678), "R1 clock rate", v, pats[i] ^ 32'h1234_5678);
        wr(23'h2E0, pats[i]); rd(23'h2E0, v);
        chk(v == (pats[i] & 32'hC000), "R1 error control mask", v, pats[i] & 32'hC000);
      end
    end
    // R5 version
    rd(23'h74, v);
    chk(v == {16'h0, 8'(NL), VID}, "R5 version", v, {16'h0, 8'(NL), VID});
    // R4 plug detect
    for (int p = 0; p < (1 << NL); p += 5) begin
      plug_det = NL'(p);
      e = '0;
      for (int n = 0; n < NL; n++) if (p[n]) e |= lbit(n);
      rd(23'h18, v);
      chk(v == e, "R4 plug detect", v, e);
    end
    plug_det = '0;
    // R2 / R3 per-link set and clear
    for (int n = 0; n < 32; n++) begin
      wr(23'h18, lbit(n));
      rd(23'h10, v);
      e = (n < NL) ? lbit(n) : 32'h0;
      chk(v == e, "R2 set single enable", v, e);
      if (n < NL) chk(link_en == NL'(1 << n), "R2 link_en port", 32'(link_en), 32'(1 << n));
      wr(23'h20, lbit(n));
      rd(23'h10, v);
      chk(v == 0, "R3 clear single enable", v, 0);
    end
    wr(23'h18, 32'hFFFF_FFFF);
    wr(23'h20, 32'h5555_5555);
    rd(23'h10, v);
    chk(v == (implm & 32'hAAAA_AAAA), "R3 clear pattern", v, implm & 32'hAAAA_AAAA);
    wr(23'h10, 32'hFFFF_FFFF);
    rd(23'h10, v);
    chk(v == (implm & 32'hAAAA_AAAA), "R3 write to read alias ignored", v, implm & 32'hAAAA_AAAA);
    // R6 / R7 window sweeps
    sweep(6'b101101);
    sweep('1);
    sweep('0);
    // R8 break
    wr(23'h20, 32'hFFFF_FFFF);
    wr(23'h18, lbit(2));
    acc(1, win_addr(2, 19'h4), 32'hC0DE_0000, 0);
    chk(g_rsp && !g_err && g_link == -1 && g_brk == NL'(1 << 2), "R8 break strobe", 32'(g_brk), 32'(1 << 2));
    chk(g_brk_after == '0, "R8 break single cycle", 32'(g_brk_after), 0);
    acc(1, win_addr(3, 19'h4), 32'hC0DE_0000, 0);
    chk(g_err && g_brk == '0 && g_link == -1, "R8 break to disabled link", 32'(g_brk), 0);
    acc(1, win_addr(2, 19'h4), 32'hC0DE_0001, 1);
    chk(g_link == 2 && g_dnaddr == 19'h4 && g_brk == '0, "R8 near-miss forwarded", 32'(g_link), 2);
    acc(1, win_addr(2, 19'h8), 32'hC0DE_0000, 0);
    chk(g_link == 2 && g_brk == '0, "R8 wrong offset forwarded", 32'(g_link), 2);
    wr(23'h1D0, 32'h4000_0000);
    // R9 port reset pulses
    begin
      logic [31:0] cmds [4] = '{32'h2000_0000, 32'h1000_0000, 32'h0400_0000, 32'h3400_0000};
      logic [4:0]  exps [4] = '{5'b10000, 5'b01000, 5'b00100, 5'b11100};
      for (int i = 0; i < 4; i++) begin
        wr(23'hD0, cmds[i]);
        chk(g_pulse == exps[i], "R9 port reset pulse", 32'(g_pulse), 32'(exps[i]));
        chk(g_pulse_after == '0, "R9 pulse single cycle", 32'(g_pulse_after), 0);
      end
    end
    // R10 register clear
    wr(23'h0, 32'hFFFF_FFFF); wr(23'h4, 32'hFFFF_0000); wr(23'h8, 32'h0000_0777);
    wr(23'h2E0, 32'hC000); wr(23'h18, 32'hFFFF_FFFF);
    wr(23'hD0, 32'h0800_0000);
    chk(link_en == '0, "R10 link gates dropped", 32'(link_en), 0);
    rd(23'h0, v);   chk(v == 0, "R10 mode cleared", v, 0);
    rd(23'h4, v);   chk(v == 0, "R10 delay cleared", v, 0);
    rd(23'h2E0, v); chk(v == 0, "R10 error control cleared", v, 0);
    rd(23'h10, v);  chk(v == 0, "R10 enables cleared", v, 0);
    rd(23'h8, v);   chk(v == 32'h777, "R10 clock rate kept", v, 32'h777);
    // R11 bridge resets
    acc(0, win_addr(9, 19'h0), '0, 0);
    wr(23'h1D0, 32'h8000_0000);
    chk(g_pulse == 5'b00010 && g_pulse_after == '0, "R11 general reset pulse", 32'(g_pulse), 2);
    rd(23'h1D0, v); chk(v == 0, "R11 status cleared by general reset", v, 0);
    rd(23'h70, v);  chk(v == 0, "R11 address cleared", v, 0);
    wr(23'h1D0, 32'h4000_0000);
    chk(g_pulse == 5'b00001, "R11 error reset pulse", 32'(g_pulse), 1);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule